// File: doc/BRIEF.md
# Shadowed Configuration Byte with Deferred Programming

This block holds one configuration byte in two places. An external nonvolatile array keeps the stored copy. A bank of working latches holds the copy that actually steers the chip: the memory-map window of the nonvolatile array, the watchdog, security, parity checking and a clock output. The latches take the stored byte on the first clock edge after reset is released. Bus reads always return the latches. Bus writes are aimed at the stored byte, so in normal operation a new value stays invisible and inactive until a later reset.

In normal mode the stored byte can only be changed through a three-step programming sequence on the control address: arm, then write the data, then start. The start strobe must stay untouched for a parameterized number of cycles. After that the block hands the byte to the array over a request/acknowledge handshake. In special mode a direct data write takes effect at once. It updates the latches and also requests programming of the array.

Top module: `cfg_shadow_reg`

## Requirements
- R1: While `rst_n` is low the latches read as 0xC2, with every implemented bit 0. On the first rising edge after release they take `nv_rdata` with bits 7, 6 and 1 forced to 1. Implemented bits are 5, 4, 3, 2 and 0.
- R2: A read of address 0 returns the latch contents, in which bits 7, 6 and 1 are always 1. A read of address 1 returns 0x00. `bus_rdata` is 0x00 when no read is selected.
- R3: In normal mode (`special_mode`=0) a write to address 0 never changes the latches, the readback or the decoded outputs before the next reset.
- R4: The normal-mode sequence is a write of 0x01 to address 1 (arm), then a write to address 0 (data), then a write of 0x03 to address 1 (start). Bit 0 is the arm bit and bit 1 the program bit. If no write follows the start, `nv_prog_req` rises exactly PROG_CYCLES clock edges after the edge that took the start write. `nv_prog_data` then carries the data, with bits 7, 6 and 1 forced to 1.
- R5: Any write while the count runs aborts the sequence. So does a start before the data write, or a second data write after the data. An abort raises no request.
- R6: `nv_prog_req` and `nv_prog_data` hold until `nv_prog_ack` is seen high at a clock edge. The request is low after that edge.
- R7: A programmed byte shows up in reads and in the decoded outputs only after the next reset.
- R8: In special mode a write to address 0 updates the latches at that edge. It also raises `nv_prog_req`, with `nv_prog_data` carrying the written value with bits 7, 6 and 1 forced to 1.
- R9: The decoded outputs follow the latches as follows:
  - `nvm_map_en` = bit 0
  - `wdog_en` = NOT bit 2
  - `sec_en` = NOT bit 3
  - `parity_en` = bit 4
  - `clkout_en` = bit 5
- R10: While a request is pending, normal-mode writes are ignored and the request stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; latches load on release |
| special_mode | input | 1 | 1 permits direct writes of the configuration byte |
| bus_cs | input | 1 | Bus access select |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 1 | 0 configuration byte, 1 programming control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| nv_rdata | input | 8 | Byte currently stored in the nonvolatile array |
| nv_prog_req | output | 1 | Request to program the array |
| nv_prog_data | output | 8 | Byte to program |
| nv_prog_ack | input | 1 | Array accepts the programming request |
| nvm_map_en | output | 1 | Nonvolatile array mapped into memory |
| wdog_en | output | 1 | Watchdog enabled |
| sec_en | output | 1 | Security mode active |
| parity_en | output | 1 | Parity checking enabled |
| clkout_en | output | 1 | Clock output enabled |

## Verification
A corrupted latch shows up at once on the address-0 readback and on the five decoded outputs, in the same cycle it forms. A wrong load at reset release therefore appears one edge after release. A sequencer that skips or repeats a state shows up as a request that rises a cycle early or late against the PROG_CYCLES count, or that rises after an aborted sequence. A data path that lets a normal write reach the latches shows up on the next read, long before any reset.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;

    localparam int CFG_W = 8;

    // Bits that exist in the working latches.
    localparam logic [CFG_W-1:0] IMPL_MASK = 8'h3D;
    // Bits that are absent and always read as one.
    localparam logic [CFG_W-1:0] FORCE_ONE = 8'hC2;

    // Latch bit positions consumed by the decoder.
    localparam int BIT_NVM_MAP  = 0;
    localparam int BIT_WDOG_OFF = 2;
    localparam int BIT_SEC_OFF  = 3;
    localparam int BIT_PARITY   = 4;
    localparam int BIT_CLKOUT   = 5;

    // Control-address bit positions.
    localparam int CTL_ARM  = 0;
    localparam int CTL_PROG = 1;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_ARMED  = 3'd1,
        SEQ_LOADED = 3'd2,
        SEQ_PROG   = 3'd3,
        SEQ_REQ    = 3'd4
    } seq_state_e;

    function automatic logic [CFG_W-1:0] cfg_shape(input logic [CFG_W-1:0] raw);
        return (raw & IMPL_MASK) | FORCE_ONE;
    endfunction

endpackage

// File: rtl/cfg_prog_seq.sv
module cfg_prog_seq
    import cfg_shadow_pkg::*;
#(
    parameter int PROG_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             ctrl_wr,
    input  logic             spec_wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             nv_prog_ack,
    output logic             nv_prog_req,
    output logic [CFG_W-1:0] nv_prog_data
);

    localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CFG_W-1:0] data;
        logic             req;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic ctl_arm, ctl_go, any_wr;

    always_comb begin
        ctl_arm = ctrl_wr &  wdata[CTL_ARM] & ~wdata[CTL_PROG];
        ctl_go  = ctrl_wr &  wdata[CTL_ARM] &  wdata[CTL_PROG];
        any_wr  = data_wr | ctrl_wr;
        seq_d   = seq_q;

        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (ctl_arm) seq_d.st = SEQ_ARMED;
            end
            SEQ_ARMED: begin
                if (data_wr) begin
                    seq_d.st   = SEQ_LOADED;
                    seq_d.data = cfg_shape(wdata);
                end else if (ctrl_wr && !ctl_arm) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            SEQ_LOADED: begin
                if (ctl_go) begin
                    seq_d.st  = SEQ_PROG;
                    seq_d.cnt = '0;
                end else if (any_wr) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            SEQ_PROG: begin
                if (any_wr) begin
                    seq_d.st = SEQ_IDLE;
                end else if (seq_q.cnt == CNT_LAST) begin
                    seq_d.st  = SEQ_REQ;
                    seq_d.req = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_REQ: begin
                if (nv_prog_ack) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.req = 1'b0;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase

        // A direct write in special mode overrides any sequence in flight.
        if (spec_wr) begin
            seq_d.st   = SEQ_REQ;
            seq_d.req  = 1'b1;
            seq_d.cnt  = '0;
            seq_d.data = cfg_shape(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= SEQ_IDLE;
            seq_q.cnt  <= '0;
            seq_q.data <= FORCE_ONE;
            seq_q.req  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign nv_prog_req  = seq_q.req;
    assign nv_prog_data = seq_q.data;

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.req && !nv_prog_ack && !spec_wr |=> seq_q.req && $stable(seq_q.data));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.req && nv_prog_ack && !spec_wr |=> !seq_q.req);

    assert_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.req) |-> $past(seq_q.st == SEQ_PROG || spec_wr));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == SEQ_PROG |-> seq_q.cnt <= CNT_LAST);

    assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == SEQ_PROG && any_wr && !spec_wr |=> seq_q.st == SEQ_IDLE && !seq_q.req);

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.st == SEQ_REQ && !nv_prog_ack && !spec_wr |=> seq_q.st == SEQ_REQ);

endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] nv_rdata,
    input  logic             spec_wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] latch_o
);

    typedef struct packed {
        logic             pend;
        logic [CFG_W-1:0] lat;
    } lat_regs_t;

    lat_regs_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (lat_q.pend) begin
            lat_d.pend = 1'b0;
            lat_d.lat  = cfg_shape(nv_rdata);
        end else if (spec_wr) begin
            lat_d.lat = cfg_shape(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q.pend <= 1'b1;
            lat_q.lat  <= FORCE_ONE;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign latch_o = lat_q.lat;

    assert_latch_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_q.pend && !spec_wr |=> $stable(lat_q.lat));

    assert_single_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q.pend |=> !lat_q.pend);

    assert_load_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q.pend |=> (lat_q.lat & IMPL_MASK) == ($past(nv_rdata) & IMPL_MASK));

endmodule

// File: rtl/cfg_shadow_reg.sv
module cfg_shadow_reg
    import cfg_shadow_pkg::*;
#(
    parameter int PROG_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       special_mode,
    input  logic       bus_cs,
    input  logic       bus_we,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] nv_rdata,
    output logic       nv_prog_req,
    output logic [7:0] nv_prog_data,
    input  logic       nv_prog_ack,
    output logic       nvm_map_en,
    output logic       wdog_en,
    output logic       sec_en,
    output logic       parity_en,
    output logic       clkout_en
);

    logic             data_wr, ctrl_wr, spec_wr, rd_cfg;
    logic [CFG_W-1:0] latch_w;

    always_comb begin
        data_wr = bus_cs & bus_we & ~bus_addr;
        ctrl_wr = bus_cs & bus_we &  bus_addr;
        spec_wr = data_wr & special_mode;
        rd_cfg  = bus_cs & ~bus_we & ~bus_addr;
    end

    cfg_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_wr      (data_wr),
        .ctrl_wr      (ctrl_wr),
        .spec_wr      (spec_wr),
        .wdata        (bus_wdata),
        .nv_prog_ack  (nv_prog_ack),
        .nv_prog_req  (nv_prog_req),
        .nv_prog_data (nv_prog_data)
    );

    cfg_latch_bank u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_rdata (nv_rdata),
        .spec_wr  (spec_wr),
        .wdata    (bus_wdata),
        .latch_o  (latch_w)
    );

    always_comb begin
        bus_rdata  = rd_cfg ? latch_w : '0;
        nvm_map_en =  latch_w[BIT_NVM_MAP];
        wdog_en    = ~latch_w[BIT_WDOG_OFF];
        sec_en     = ~latch_w[BIT_SEC_OFF];
        parity_en  =  latch_w[BIT_PARITY];
        clkout_en  =  latch_w[BIT_CLKOUT];
    end

    assert_unimpl_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cfg |-> bus_rdata[7] && bus_rdata[6] && bus_rdata[1]);

    assert_spec_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spec_wr |=> nv_prog_req && (nv_prog_data & IMPL_MASK) == ($past(bus_wdata) & IMPL_MASK));

    assert_norm_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 data_wr && !special_mode && !$past(!rst_n) |=> $stable(wdog_en) && $stable(nvm_map_en));

endmodule

// File: tb/cfg_shadow_reg_tb.sv
module cfg_shadow_reg_tb;

    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       special_mode = 1'b0;
    logic       bus_cs = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] nv_byte = 8'h00;
    logic       nv_prog_req;
    logic [7:0] nv_prog_data;
    logic       nv_prog_ack = 1'b0;
    logic       nvm_map_en, wdog_en, sec_en, parity_en, clkout_en;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cfg_shadow_reg #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .nv_rdata(nv_byte), .nv_prog_req(nv_prog_req),
        .nv_prog_data(nv_prog_data), .nv_prog_ack(nv_prog_ack),
        .nvm_map_en(nvm_map_en), .wdog_en(wdog_en), .sec_en(sec_en),
        .parity_en(parity_en), .clkout_en(clkout_en)
    );

    function automatic logic [7:0] expect_byte(input logic [7:0] v);
        return {2'b11, v[5], v[4], v[3], v[2], 1'b1, v[0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_outputs(input string req, input logic [7:0] v);
        logic [7:0] e;
        e = expect_byte(v);
        chk(req, {27'd0, nvm_map_en, wdog_en, sec_en, parity_en, clkout_en},
            {27'd0, e[0], ~e[2], ~e[3], e[4], e[5]});
    endtask

    task automatic take_ack();
        nv_byte = nv_prog_data;
        nv_prog_ack = 1'b1;
        @(negedge clk);
        nv_prog_ack = 1'b0;
        chk("R6 request drops after ack", {31'd0, nv_prog_req}, 32'd0);
    endtask

    task automatic no_req_for(input string req, input int n);
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (nv_prog_req) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;

        // R1: state held in reset
        repeat (2) @(negedge clk);
        rd(1'b0, r);
        chk("R1 reset latch value", {24'd0, r}, 32'hC2);
        chk("R1 no request in reset", {31'd0, nv_prog_req}, 32'd0);
        check_outputs("R9 outputs in reset", 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R9: load from every stored value
        for (int v = 0; v < 256; v++) begin
            nv_byte = 8'(v);
            do_reset();
            rd(1'b0, r);
            chk("R1 load at release", {24'd0, r}, {24'd0, expect_byte(8'(v))});
            check_outputs("R9 decode", 8'(v));
        end
        rd(1'b1, r);
        chk("R2 control address reads zero", {24'd0, r}, 32'd0);
        chk("R2 idle rdata zero", {24'd0, bus_rdata}, 32'd0);

        // R3: every normal write is ignored by the latches
        nv_byte = 8'h00;
        do_reset();
        for (int v = 0; v < 256; v++) begin
            wr(1'b0, 8'(v));
            rd(1'b0, r);
            chk("R3 normal write no effect", {24'd0, r}, 32'hC2);
            check_outputs("R3 outputs unchanged", 8'h00);
        end
        chk("R3 no request from stray write", {31'd0, nv_prog_req}, 32'd0);

        // R4: full sequence and its timing
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h5A);
        wr(1'b1, 8'h03);
        for (int k = 1; k < P; k++) begin
            @(negedge clk);
            chk("R4 no request before count", {31'd0, nv_prog_req}, 32'd0);
        end
        @(negedge clk);
        chk("R4 request after count", {31'd0, nv_prog_req}, 32'd1);
        chk("R4 program data", {24'd0, nv_prog_data}, {24'd0, expect_byte(8'h5A)});

        // R6, R10: hold while unacknowledged, ignore writes
        wr(1'b1, 8'h00);
        wr(1'b0, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R10 request survives writes", {31'd0, nv_prog_req}, 32'd1);
        chk("R6 data stable while pending", {24'd0, nv_prog_data}, {24'd0, expect_byte(8'h5A)});
        take_ack();

        // R7: new value deferred to next reset
        rd(1'b0, r);
        chk("R7 not visible before reset", {24'd0, r}, 32'hC2);
        do_reset();
        rd(1'b0, r);
        chk("R7 visible after reset", {24'd0, r}, {24'd0, expect_byte(8'h5A)});
        check_outputs("R7 outputs after reset", 8'h5A);

        // R5: aborts
        wr(1'b1, 8'h01); wr(1'b0, 8'h00); wr(1'b1, 8'h03);
        @(negedge clk);
        wr(1'b1, 8'h03);
        no_req_for("R5 write during count aborts", P + 4);
        wr(1'b1, 8'h01); wr(1'b1, 8'h03); wr(1'b0, 8'h00);
        no_req_for("R5 start before data aborts", P + 4);
        wr(1'b1, 8'h01); wr(1'b0, 8'h00); wr(1'b0, 8'h00); wr(1'b1, 8'h03);
        no_req_for("R5 double data aborts", P + 4);
        do_reset();
        rd(1'b0, r);
        chk("R5 stored byte untouched", {24'd0, r}, {24'd0, expect_byte(8'h5A)});

        // R8: direct writes in special mode
        special_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            wr(1'b0, 8'(v));
            rd(1'b0, r);
            chk("R8 latch takes direct write", {24'd0, r}, {24'd0, expect_byte(8'(v))});
            check_outputs("R8 outputs follow", 8'(v));
            chk("R8 request raised", {31'd0, nv_prog_req}, 32'd1);
            chk("R8 request data", {24'd0, nv_prog_data}, {24'd0, expect_byte(8'(v))});
            take_ack();
        end
        special_mode = 1'b0;
        do_reset();
        rd(1'b0, r);
        chk("R7 last direct write stored", {24'd0, r}, 32'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule